// File: doc/BRIEF.md
# Mailbox Request Router

This block sits between a host register port and a set of numbered service endpoints. A host write to the send window carries a request word whose low four bits name the target channel. An idle channel receives the word at once as a one-cycle pulse. A busy channel causes the word to be parked in a request queue. A write to a channel number that does not exist is dropped and flagged, and so is any send that arrives while the request queue is full.

In the other direction, the block watches each endpoint's response-valid line. Every clock it grants the lowest-numbered endpoint that has a word ready, provided the response queue has room. This continues until every endpoint is drained or the queue fills. A granted word equal to the all-ones sentinel breaks the endpoint protocol. Such a word is consumed, never queued, and flagged. An interrupt line reports a non-empty response queue when it is enabled.

Response transfers follow valid/ready rules. A word moves on a clock edge where `ch_rsp_valid[i]` and `ch_rsp_ready[i]` are both high. An endpoint must hold its word stable while it is valid and not yet granted. Both queue outputs are valid/ready streams, and a word leaves a queue on an edge where valid and ready are both high. The request pulse toward an endpoint has no ready signal. The endpoint's busy level takes that role and is sampled in the write cycle.

Top module: `mbox_router`

## Requirements
- R1: A write with `wr_addr[7:4]` equal to 4'hA is a send, whatever the value of `wr_addr[3:0]` (0xA0, 0xA4, 0xA8, 0xAC and the bytes between). A write to any other address changes no output and no queue.
- R2: A send that arrives while the request queue holds REQ_DEPTH words is discarded, whatever its channel. `err_ovf` is high for exactly the one cycle after the write, and nothing is delivered.
- R3: The channel is `wr_data[3:0]`. If the queue has room and the channel is at or above NUM_CH (9), the word is discarded, `err_chan` pulses for one cycle after the write, and nothing is delivered or queued.
- R4: A send to a valid channel whose `ch_busy` bit is low drives `ch_req_valid` to the one-hot bit of that channel for exactly the cycle after the write, with `ch_req_data` equal to the whole 32-bit word.
- R5: A send to a valid channel whose `ch_busy` bit is high pushes the whole word into the request queue, with no delivery. The word appears on `req_q_data` the cycle after the write.
- R6: Each cycle in which the response queue is not full, `ch_rsp_ready` is one-hot on the lowest index whose `ch_rsp_valid` is high. At most one response word is moved per clock.
- R7: While the response queue holds RSP_DEPTH words, `ch_rsp_ready` is all zero and endpoint words wait.
- R8: A granted response word equal to 32'hFFFF_FFFF is consumed without being queued, and `err_proto` is high for the one cycle after the transfer.
- R9: `irq` is high exactly when `irq_en` is high and the response queue is non-empty.
- R10: After reset both queues are empty, `ch_req_valid`, `ch_rsp_ready`, `irq` and all error flags are low.
- R11: Both queues return words in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write strobe, one word per cycle |
| wr_addr | input | 8 | Host write byte address |
| wr_data | input | 32 | Host write word; bits 3:0 carry the channel |
| ch_busy | input | NUM_CH | Per-endpoint busy level |
| ch_req_valid | output | NUM_CH | One-cycle one-hot request pulse |
| ch_req_data | output | 32 | Request word delivered to an endpoint |
| ch_rsp_valid | input | NUM_CH | Per-endpoint response available |
| ch_rsp_data | input | NUM_CH*32 | Response words, endpoint i at bits 32*i+31:32*i |
| ch_rsp_ready | output | NUM_CH | One-hot grant to an endpoint |
| req_q_valid | output | 1 | Request queue non-empty |
| req_q_data | output | 32 | Oldest deferred request |
| req_q_ready | input | 1 | Removes the oldest deferred request |
| rsp_out_valid | output | 1 | Response queue non-empty |
| rsp_out_data | output | 32 | Oldest response word |
| rsp_out_ready | input | 1 | Removes the oldest response word |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Response-pending interrupt |
| err_ovf | output | 1 | Send dropped on a full request queue |
| err_chan | output | 1 | Send dropped on a bad channel number |
| err_proto | output | 1 | Sentinel word received from an endpoint |

## Verification
Sends are tried in four forms: an idle channel, a busy channel, a channel number past the top, and a full request queue. Together they separate the four dispositions and show that the full-queue check takes precedence over the channel check. Address aliases and a write outside the send window show that only the upper address nibble selects a send. On the response side, two endpoints raised together show the ascending-index order. A six-word burst from one endpoint shows the stall at a full queue and the resumption after one pop. A sentinel followed by a good word shows that only the bad word is dropped.

// File: rtl/mbox_router_pkg.sv
package mbox_router_pkg;
  localparam int CH_W = 4;
  localparam logic [3:0] SEND_PAGE = 4'hA;

  typedef enum logic [2:0] {
    DISP_NONE,
    DISP_DELIVER,
    DISP_DEFER,
    DISP_DROP_FULL,
    DISP_DROP_CHAN
  } disp_e;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == DEPTH_C);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mbox_send_decode.sv
module mbox_send_decode
  import mbox_router_pkg::*;
#(
  parameter int NUM_CH = 9,
  parameter int ADDR_W = 8
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [NUM_CH-1:0] ch_busy,
  input  logic              req_full,
  output disp_e             disp,
  output logic [NUM_CH-1:0] target
);
  localparam logic [CH_W:0]     CH_LIMIT = (CH_W+1)'(NUM_CH);
  localparam logic [NUM_CH-1:0] ONE      = NUM_CH'(1);

  logic is_send, chan_ok;

  assign is_send = wr_valid && (wr_addr[ADDR_W-1 -: 4] == SEND_PAGE);
  assign chan_ok = ({1'b0, wr_chan} < CH_LIMIT);
  assign target  = chan_ok ? (ONE << wr_chan) : '0;

  always_comb begin
    disp = DISP_NONE;
    if (is_send) begin
      if (req_full)                disp = DISP_DROP_FULL;
      else if (!chan_ok)           disp = DISP_DROP_CHAN;
      else if (|(ch_busy & target)) disp = DISP_DEFER;
      else                         disp = DISP_DELIVER;
    end
  end
endmodule

// File: rtl/mbox_rsp_scan.sv
module mbox_rsp_scan #(
  parameter int NUM_CH = 9,
  parameter int DW     = 32
) (
  input  logic                 enable,
  input  logic [NUM_CH-1:0]    avail,
  input  logic [NUM_CH*DW-1:0] words,
  output logic [NUM_CH-1:0]    grant,
  output logic [DW-1:0]        sel_word
);
  logic [NUM_CH:0]    seen;
  logic [DW-1:0]      masked [NUM_CH];
  logic [DW-1:0]      acc    [NUM_CH+1];

  assign seen[0] = 1'b0;
  assign acc[0]  = '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    assign seen[i+1]  = seen[i] | avail[i];
    assign grant[i]   = enable && avail[i] && !seen[i];
    assign masked[i]  = grant[i] ? words[i*DW +: DW] : '0;
    assign acc[i+1]   = acc[i] | masked[i];
  end

  assign sel_word = acc[NUM_CH];
endmodule

// File: rtl/mbox_router.sv
module mbox_router
  import mbox_router_pkg::*;
#(
  parameter int NUM_CH    = 9,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int REQ_DEPTH = 4,
  parameter int RSP_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NUM_CH-1:0]        ch_busy,
  output logic [NUM_CH-1:0]        ch_req_valid,
  output logic [DATA_W-1:0]        ch_req_data,
  input  logic [NUM_CH-1:0]        ch_rsp_valid,
  input  logic [NUM_CH*DATA_W-1:0] ch_rsp_data,
  output logic [NUM_CH-1:0]        ch_rsp_ready,
  output logic                     req_q_valid,
  output logic [DATA_W-1:0]        req_q_data,
  input  logic                     req_q_ready,
  output logic                     rsp_out_valid,
  output logic [DATA_W-1:0]        rsp_out_data,
  input  logic                     rsp_out_ready,
  input  logic                     irq_en,
  output logic                     irq,
  output logic                     err_ovf,
  output logic                     err_chan,
  output logic                     err_proto
);
  localparam logic [DATA_W-1:0] SENTINEL = '1;

  disp_e             disp;
  logic [NUM_CH-1:0] target;
  logic              req_full, req_empty;
  logic              rsp_full, rsp_empty;
  logic              rsp_take, rsp_bad;
  logic [DATA_W-1:0] rsp_sel_data;

  mbox_send_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_chan  (wr_data[CH_W-1:0]),
    .ch_busy  (ch_busy),
    .req_full (req_full),
    .disp     (disp),
    .target   (target)
  );

  mbox_fifo #(.DW(DATA_W), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (disp == DISP_DEFER),
    .push_data (wr_data),
    .pop       (req_q_ready),
    .head      (req_q_data),
    .empty     (req_empty),
    .full      (req_full)
  );

  mbox_rsp_scan #(.NUM_CH(NUM_CH), .DW(DATA_W)) u_scan (
    .enable   (!rsp_full),
    .avail    (ch_rsp_valid),
    .words    (ch_rsp_data),
    .grant    (ch_rsp_ready),
    .sel_word (rsp_sel_data)
  );

  assign rsp_take = |ch_rsp_ready;
  assign rsp_bad  = (rsp_sel_data == SENTINEL);

  mbox_fifo #(.DW(DATA_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rsp_take && !rsp_bad),
    .push_data (rsp_sel_data),
    .pop       (rsp_out_ready),
    .head      (rsp_out_data),
    .empty     (rsp_empty),
    .full      (rsp_full)
  );

  assign req_q_valid   = !req_empty;
  assign rsp_out_valid = !rsp_empty;
  assign irq           = irq_en && !rsp_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_req_valid <= '0;
      ch_req_data  <= '0;
      err_ovf      <= 1'b0;
      err_chan     <= 1'b0;
      err_proto    <= 1'b0;
    end else begin
      ch_req_valid <= (disp == DISP_DELIVER) ? target : '0;
      if (disp == DISP_DELIVER) ch_req_data <= wr_data;
      err_ovf      <= (disp == DISP_DROP_FULL);
      err_chan     <= (disp == DISP_DROP_CHAN);
      err_proto    <= rsp_take && rsp_bad;
    end
  end
endmodule

// File: rtl/mbox_router_chk.sv
module mbox_router_chk #(
  parameter int NUM_CH = 9,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NUM_CH-1:0] ch_busy,
  input logic [NUM_CH-1:0] ch_req_valid,
  input logic [NUM_CH-1:0] ch_rsp_valid,
  input logic [NUM_CH-1:0] ch_rsp_ready,
  input logic              req_q_valid,
  input logic              err_ovf,
  input logic              err_chan,
  input logic              err_proto,
  input logic              req_full,
  input logic              rsp_full,
  input logic              rsp_take,
  input logic [DATA_W-1:0] rsp_sel_data
);
  logic send, chan_bad;
  assign send     = wr_valid && (wr_addr[ADDR_W-1 -: 4] == 4'hA);
  assign chan_bad = (int'(wr_data[3:0]) >= NUM_CH);

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send && req_full |=> err_ovf && (ch_req_valid == '0));

  // R3
  bad_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send && !req_full && chan_bad |=> err_chan && !err_ovf && (ch_req_valid == '0));

  // R4
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_req_valid));

  // R5
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send && !req_full && !chan_bad && ch_busy[wr_data[3:0]] |=> req_q_valid && (ch_req_valid == '0));

  // R6
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rsp_ready) && ((ch_rsp_ready & ~ch_rsp_valid) == '0));

  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_full |-> (ch_rsp_ready == '0));

  // R8
  sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && (rsp_sel_data == '1) |=> err_proto);
endmodule

bind mbox_router mbox_router_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .ch_busy      (ch_busy),
  .ch_req_valid (ch_req_valid),
  .ch_rsp_valid (ch_rsp_valid),
  .ch_rsp_ready (ch_rsp_ready),
  .req_q_valid  (req_q_valid),
  .err_ovf      (err_ovf),
  .err_chan     (err_chan),
  .err_proto    (err_proto),
  .req_full     (req_full),
  .rsp_full     (rsp_full),
  .rsp_take     (rsp_take),
  .rsp_sel_data (rsp_sel_data)
);

// File: tb/mbox_router_test.sv
module mbox_router_test;
  localparam int NCH = 9;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NCH-1:0] ch_busy = '0;
  logic [NCH-1:0] ch_req_valid;
  logic [DW-1:0]  ch_req_data;
  logic [NCH-1:0] ch_rsp_valid;
  logic [NCH*DW-1:0] ch_rsp_data;
  logic [NCH-1:0] ch_rsp_ready;
  logic          req_q_valid;
  logic [DW-1:0] req_q_data;
  logic          req_q_ready = 1'b0;
  logic          rsp_out_valid;
  logic [DW-1:0] rsp_out_data;
  logic          rsp_out_ready = 1'b0;
  logic          irq_en = 1'b0;
  logic          irq, err_ovf, err_chan, err_proto;

  int checks = 0;
  int errors = 0;
  int ep_load  [NCH];
  int ep_taken [NCH];
  int ep_bad   [NCH];

  always #2 clk = ~clk;

  mbox_router uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .ch_busy(ch_busy), .ch_req_valid(ch_req_valid), .ch_req_data(ch_req_data),
    .ch_rsp_valid(ch_rsp_valid), .ch_rsp_data(ch_rsp_data), .ch_rsp_ready(ch_rsp_ready),
    .req_q_valid(req_q_valid), .req_q_data(req_q_data), .req_q_ready(req_q_ready),
    .rsp_out_valid(rsp_out_valid), .rsp_out_data(rsp_out_data), .rsp_out_ready(rsp_out_ready),
    .irq_en(irq_en), .irq(irq), .err_ovf(err_ovf), .err_chan(err_chan), .err_proto(err_proto)
  );

  function automatic logic [DW-1:0] pat(int ch, int seq);
    return {16'hBEEF, 8'(ch), 8'(seq)};
  endfunction

  // endpoint model: valid while words remain, advance on handshake
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_rsp_valid[i] = ep_load[i] > ep_taken[i];
      ch_rsp_data[i*DW +: DW] = (ep_bad[i] == ep_taken[i]) ? '1 : pat(i, ep_taken[i]);
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      ep_taken[i] = 0;
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (ch_rsp_valid[i] && ch_rsp_ready[i]) ep_taken[i] <= ep_taken[i] + 1;
    end
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one write; returns at the negedge after the capturing edge
  task automatic send(logic [7:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop_req(string req, logic [DW-1:0] exp);
    chk(req, {31'b0, req_q_valid}, 1);
    chk(req, req_q_data, exp);
    req_q_ready = 1'b1;
    @(negedge clk);
    req_q_ready = 1'b0;
  endtask

  task automatic pop_rsp(string req, logic [DW-1:0] exp);
    chk(req, {31'b0, rsp_out_valid}, 1);
    chk(req, rsp_out_data, exp);
    rsp_out_ready = 1'b1;
    @(negedge clk);
    rsp_out_ready = 1'b0;
  endtask

  task automatic t_reset();
    // R10
    chk("R10 req_q_valid", {31'b0, req_q_valid}, 0);
    chk("R10 rsp_out_valid", {31'b0, rsp_out_valid}, 0);
    chk("R10 ch_req_valid", DW'(ch_req_valid), 0);
    chk("R10 ch_rsp_ready", DW'(ch_rsp_ready), 0);
    chk("R10 flags", {28'b0, irq, err_ovf, err_chan, err_proto}, 0);
  endtask

  task automatic t_deliver();
    // R4
    send(8'hA0, 32'h1234_5673);
    chk("R4 pulse", DW'(ch_req_valid), DW'(1 << 3));
    chk("R4 data", ch_req_data, 32'h1234_5673);
    chk("R4 not queued", {31'b0, req_q_valid}, 0);
    @(negedge clk);
    chk("R4 one cycle", DW'(ch_req_valid), 0);
  endtask

  task automatic t_alias();
    // R1
    send(8'hAC, 32'h0000_BB08);
    chk("R1 alias 0xAC", DW'(ch_req_valid), DW'(1 << 8));
    send(8'hA6, 32'h0000_CC00);
    chk("R1 alias 0xA6", DW'(ch_req_valid), DW'(1));
    send(8'h9C, 32'h0000_DD01);
    chk("R1 other addr", {DW'(ch_req_valid)} | {31'b0, req_q_valid}, 0);
    chk("R1 other addr err", {30'b0, err_chan, err_ovf}, 0);
  endtask

  task automatic t_badchan();
    // R3
    send(8'hA4, 32'h0000_EE0B);
    chk("R3 err_chan", {31'b0, err_chan}, 1);
    chk("R3 no delivery", DW'(ch_req_valid), 0);
    chk("R3 no queue", {31'b0, req_q_valid}, 0);
    send(8'hA4, 32'h0000_EE09);
    chk("R3 chan 9", {31'b0, err_chan}, 1);
    @(negedge clk);
    chk("R3 pulse end", {31'b0, err_chan}, 0);
  endtask

  task automatic t_defer_full();
    // R5, R2, R11
    ch_busy = NCH'(1 << 4);
    send(8'hA0, 32'h5000_0004);
    chk("R5 queued", {31'b0, req_q_valid}, 1);
    chk("R5 head", req_q_data, 32'h5000_0004);
    chk("R5 no delivery", DW'(ch_req_valid), 0);
    for (int k = 1; k < 4; k++) send(8'hA0, 32'h5000_0004 | (k << 8));
    send(8'hA8, 32'h6000_0004);
    chk("R2 err_ovf busy", {31'b0, err_ovf}, 1);
    send(8'hA8, 32'h6000_0001);
    chk("R2 err_ovf idle ch", {31'b0, err_ovf}, 1);
    chk("R2 no delivery", DW'(ch_req_valid), 0);
    send(8'hA8, 32'h6000_000C);
    chk("R2 precedes R3", {30'b0, err_ovf, err_chan}, 2);
    ch_busy = '0;
    for (int k = 0; k < 4; k++) pop_req("R11 req order", 32'h5000_0004 | (k << 8));
    chk("R11 req drained", {31'b0, req_q_valid}, 0);
  endtask

  task automatic t_scan();
    // R6, R9, R11
    @(negedge clk);
    ep_load[2] = ep_taken[2] + 2;
    ep_load[5] = ep_taken[5] + 1;
    #1;
    chk("R6 lowest first", DW'(ch_rsp_ready), DW'(1 << 2));
    @(negedge clk);
    chk("R9 irq masked", {31'b0, irq}, 0);
    irq_en = 1'b1;
    #1;
    chk("R9 irq", {31'b0, irq}, 1);
    @(negedge clk);
    @(negedge clk);
    chk("R6 all taken", DW'(ch_rsp_valid), 0);
    pop_rsp("R6 order a", pat(2, 0));
    pop_rsp("R6 order b", pat(2, 1));
    pop_rsp("R6 order c", pat(5, 0));
    chk("R9 irq clear", {31'b0, irq}, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_rspfull();
    // R7, R11
    int base;
    @(negedge clk);
    base = ep_taken[0];
    ep_load[0] = base + 6;
    repeat (5) @(negedge clk);
    chk("R7 four taken", DW'(ep_taken[0] - base), 4);
    chk("R7 stalled", DW'(ch_rsp_ready), 0);
    for (int k = 0; k < 6; k++) begin
      if (!rsp_out_valid) @(negedge clk);
      pop_rsp("R11 rsp order", pat(0, base + k));
    end
    @(negedge clk);
    chk("R11 rsp drained", {31'b0, rsp_out_valid}, 0);
  endtask

  task automatic t_sentinel();
    // R8
    int base;
    @(negedge clk);
    base = ep_taken[3];
    ep_bad[3] = base;
    ep_load[3] = base + 2;
    @(negedge clk);
    chk("R8 err_proto", {31'b0, err_proto}, 1);
    @(negedge clk);
    chk("R8 pulse end", {31'b0, err_proto}, 0);
    pop_rsp("R8 good word kept", pat(3, base + 1));
    chk("R8 bad word dropped", {31'b0, rsp_out_valid}, 0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      ep_load[i] = 0;
      ep_bad[i] = -1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_deliver();
    t_alias();
    t_badchan();
    t_defer_full();
    t_scan();
    t_rspfull();
    t_sentinel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule